// File: doc/BRIEF.md
# Command Halt Bridge with Gated Microcontroller RAM Window

This block joins a 16-bit host processor to a small 8-bit helper microcontroller that computes results for the host. The host starts a job by writing to a command word. That write raises an interrupt request to the microcontroller and halts the host in the next cycle. While the host is stopped, the microcontroller reads and writes a 16-byte slice of host work RAM through its external data space. It then ends its interrupt routine by driving a bit of its port 3 from high to low, and that falling edge lets the host continue.

The microcontroller window is translated so that consecutive microcontroller bytes land on the odd byte lanes of the top 32 bytes of host RAM. The window is opened and closed by a second port 3 bit. A single byte-wide RAM port is shared between host cycles and window cycles, and the window wins any conflict.

Top module: `mcu_window_bridge`

## Requirements
- R1: After reset, `host_halt` and `mcu_int0` are low, and the stored port 3 value is 0xFF, so the window starts closed.
- R2: With the window open, an MCU access at data address 0x7F0+n (n = 0..15) drives one RAM cycle at host byte address 0xFFFFE0 | (n<<1) | 1. A read returns the RAM byte on `mcu_rdata`, and a write presents `mcu_wdata` with `ram_we` high, in the same cycle.
- R3: MCU accesses outside 0x7F0..0x7FF start no RAM cycle, and reads return 0xFF.
- R4: While stored port 3 bit 5 is 1, window reads return 0xFF and window writes start no RAM cycle. Writing bit 5 as 0 opens the window from the cycle after the port write.
- R5: A host write (`host_req` and `host_we`) to either byte of the command word 0xFE4002/0xFE4003 sets `host_halt` and `mcu_int0` from the next cycle.
- R6: The host is released only by a port 3 write whose bit 0 is 0 while the stored bit 0 is 1. That write clears `host_halt` and `mcu_int0` from the next cycle. Writes of 1 over 1, 0 over 0, or 1 over 0 leave the halt unchanged.
- R7: `mcu_int_ack` clears `mcu_int0` from the next cycle and leaves `host_halt` set.
- R8: A command write made while the host is halted has no effect: `mcu_int0` stays low after an acknowledge, and `host_halt` stays high.
- R9: When an MCU window access and a host request fall in the same cycle, the RAM port carries the MCU cycle and `host_gnt` is low. A lone host request is granted and passed to the RAM port unchanged.
- R10: A command write never reaches the RAM port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Host bus cycle request |
| host_we | input | 1 | Host cycle is a write |
| host_addr | input | 24 | Host byte address |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte (zero when not granted) |
| host_gnt | output | 1 | Host cycle accepted this clock |
| host_halt | output | 1 | Host stall request |
| mcu_rd | input | 1 | MCU external data read strobe |
| mcu_wr | input | 1 | MCU external data write strobe |
| mcu_addr | input | 11 | MCU external data address |
| mcu_wdata | input | 8 | MCU write byte |
| mcu_rdata | output | 8 | MCU read byte |
| mcu_p3_wr | input | 1 | MCU port 3 output update strobe |
| mcu_p3_wdata | input | 8 | New MCU port 3 value |
| mcu_int0 | output | 1 | Interrupt request to the MCU |
| mcu_int_ack | input | 1 | MCU accepted the interrupt |
| ram_en | output | 1 | Work RAM cycle enable |
| ram_we | output | 1 | Work RAM write enable |
| ram_addr | output | 24 | Work RAM byte address |
| ram_wdata | output | 8 | Work RAM write byte |
| ram_rdata | input | 8 | Work RAM read byte (combinational) |

## Verification
The hardest case to reach is a window access that collides with a host request. A correct system only allows this while the host is halted, so the bench first opens the window through port 3, issues a command, and then drives an MCU read and a host request in the same cycle. A second hard case is the ignored re-command: the request must be acknowledged before a stray command write could show up on `mcu_int0`, so the bench acknowledges first and then writes the command again while halted. Release is covered with every combination of old and new port 3 bit 0, including a release that arrives before any acknowledge.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

   // Who owns the shared RAM port in a given cycle.
   typedef enum logic [1:0] {
      OWN_IDLE = 2'd0,
      OWN_HOST = 2'd1,
      OWN_MCU  = 2'd2
   } ram_owner_e;

   // log2 for power-of-two sizes used in elaboration checks.
   function automatic int unsigned clog2_pos(input int unsigned v);
      int unsigned r;
      r = 0;
      while ((1 << r) < v) r++;
      return r;
   endfunction

endpackage

// File: rtl/mwb_port3_track.sv
module mwb_port3_track #(
   parameter int unsigned P3_W            = 8,
   parameter int unsigned GATE_BIT        = 5,
   parameter int unsigned DONE_BIT        = 0,
   parameter logic [P3_W-1:0] RESET_VAL   = '1,
   parameter bit          GATE_ACTIVE_LOW = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            p3_wr,
   input  logic [P3_W-1:0] p3_wdata,
   output logic            win_open,
   output logic            done_fall
);

   if (GATE_BIT >= P3_W) begin : g_bad_gate
      $error("GATE_BIT outside port width");
   end
   if (DONE_BIT >= P3_W) begin : g_bad_done
      $error("DONE_BIT outside port width");
   end
   if (GATE_BIT == DONE_BIT) begin : g_bad_share
      $error("gate and completion bits must differ");
   end

   logic [P3_W-1:0] p3_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p3_q <= RESET_VAL;
      end else if (p3_wr) begin
         p3_q <= p3_wdata;
      end
   end

   // completion edge: stored 1, newly written 0
   assign done_fall = p3_wr & p3_q[DONE_BIT] & ~p3_wdata[DONE_BIT];

   if (GATE_ACTIVE_LOW) begin : g_gate_low
      assign win_open = ~p3_q[GATE_BIT];
   end else begin : g_gate_high
      assign win_open = p3_q[GATE_BIT];
   end

endmodule

// File: rtl/mwb_win_xlate.sv
module mwb_win_xlate #(
   parameter int unsigned MCU_AW                  = 11,
   parameter int unsigned HOST_AW                 = 24,
   parameter int unsigned WIN_BYTES               = 16,
   parameter logic [MCU_AW-1:0]  MCU_WIN_BASE     = 11'h7F0,
   parameter logic [HOST_AW-1:0] HOST_WIN_BASE    = 24'hFFFFE0,
   parameter bit                 ODD_LANE         = 1'b1
) (
   input  logic [MCU_AW-1:0]  mcu_addr,
   output logic               win_hit,
   output logic [HOST_AW-1:0] host_byte_addr
);

   import mwb_pkg::*;

   localparam int unsigned OFF_W = clog2_pos(WIN_BYTES);
   localparam logic [OFF_W:0] HOST_LOW_ZERO = '0;

   if ((1 << OFF_W) != WIN_BYTES) begin : g_bad_size
      $error("WIN_BYTES must be a power of two");
   end
   if (OFF_W + 1 >= HOST_AW || OFF_W >= MCU_AW) begin : g_bad_width
      $error("window wider than an address bus");
   end
   if (MCU_WIN_BASE[OFF_W-1:0] != '0) begin : g_bad_mbase
      $error("MCU window base not aligned");
   end
   if (HOST_WIN_BASE[OFF_W:0] != HOST_LOW_ZERO) begin : g_bad_hbase
      $error("host window base not aligned to twice the window");
   end

   logic [OFF_W-1:0] offset;

   assign offset  = mcu_addr[OFF_W-1:0];
   assign win_hit = (mcu_addr[MCU_AW-1:OFF_W] == MCU_WIN_BASE[MCU_AW-1:OFF_W]);

   // every MCU byte lands on one lane of a host 16-bit word
   if (ODD_LANE) begin : g_odd
      assign host_byte_addr = {HOST_WIN_BASE[HOST_AW-1:OFF_W+1], offset, 1'b1};
   end else begin : g_even
      assign host_byte_addr = {HOST_WIN_BASE[HOST_AW-1:OFF_W+1], offset, 1'b0};
   end

endmodule

// File: rtl/mwb_halt_ctrl.sv
module mwb_halt_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_wr,
   input  logic done_fall,
   input  logic int_ack,
   output logic halted,
   output logic int_req
);

   logic halted_q;
   logic int_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         int_q    <= 1'b0;
      end else if (halted_q) begin
         // a new command while stalled is dropped
         if (done_fall) begin
            halted_q <= 1'b0;
            int_q    <= 1'b0;
         end else if (int_ack) begin
            int_q    <= 1'b0;
         end
      end else if (cmd_wr) begin
         halted_q <= 1'b1;
         int_q    <= 1'b1;
      end
   end

   assign halted  = halted_q;
   assign int_req = int_q;

endmodule

// File: rtl/mwb_ram_arb.sv
module mwb_ram_arb #(
   parameter int unsigned HOST_AW = 24,
   parameter int unsigned DATA_W  = 8
) (
   input  logic               mcu_req,
   input  logic               mcu_we,
   input  logic [HOST_AW-1:0] mcu_addr,
   input  logic [DATA_W-1:0]  mcu_wdata,
   input  logic               host_any,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output mwb_pkg::ram_owner_e owner,
   output logic               host_gnt,
   output logic               ram_en,
   output logic               ram_we,
   output logic [HOST_AW-1:0] ram_addr,
   output logic [DATA_W-1:0]  ram_wdata
);

   import mwb_pkg::*;

   always_comb begin
      if (mcu_req) begin
         owner = OWN_MCU;
      end else if (host_req) begin
         owner = OWN_HOST;
      end else begin
         owner = OWN_IDLE;
      end
   end

   // host is only ever blocked by a window cycle
   assign host_gnt = host_any & ~mcu_req;

   always_comb begin
      ram_en    = 1'b0;
      ram_we    = 1'b0;
      ram_addr  = '0;
      ram_wdata = '0;
      unique case (owner)
         OWN_MCU: begin
            ram_en    = 1'b1;
            ram_we    = mcu_we;
            ram_addr  = mcu_addr;
            ram_wdata = mcu_wdata;
         end
         OWN_HOST: begin
            ram_en    = 1'b1;
            ram_we    = host_we;
            ram_addr  = host_addr;
            ram_wdata = host_wdata;
         end
         default: begin
            ram_en = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/mcu_window_bridge.sv
module mcu_window_bridge #(
   parameter int unsigned HOST_AW              = 24,
   parameter int unsigned MCU_AW               = 11,
   parameter int unsigned DATA_W               = 8,
   parameter int unsigned P3_W                 = 8,
   parameter int unsigned WIN_BYTES            = 16,
   parameter logic [MCU_AW-1:0]  MCU_WIN_BASE  = 11'h7F0,
   parameter logic [HOST_AW-1:0] HOST_WIN_BASE = 24'hFFFFE0,
   parameter logic [HOST_AW-1:0] CMD_ADDR      = 24'hFE4002,
   parameter int unsigned GATE_BIT             = 5,
   parameter int unsigned DONE_BIT             = 0,
   parameter bit          ODD_LANE             = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               host_req,
   input  logic               host_we,
   input  logic [HOST_AW-1:0] host_addr,
   input  logic [DATA_W-1:0]  host_wdata,
   output logic [DATA_W-1:0]  host_rdata,
   output logic               host_gnt,
   output logic               host_halt,
   input  logic               mcu_rd,
   input  logic               mcu_wr,
   input  logic [MCU_AW-1:0]  mcu_addr,
   input  logic [DATA_W-1:0]  mcu_wdata,
   output logic [DATA_W-1:0]  mcu_rdata,
   input  logic               mcu_p3_wr,
   input  logic [P3_W-1:0]    mcu_p3_wdata,
   output logic               mcu_int0,
   input  logic               mcu_int_ack,
   output logic               ram_en,
   output logic               ram_we,
   output logic [HOST_AW-1:0] ram_addr,
   output logic [DATA_W-1:0]  ram_wdata,
   input  logic [DATA_W-1:0]  ram_rdata
);

   import mwb_pkg::*;

   localparam logic [DATA_W-1:0] IDLE_READ = '1;
   localparam logic [P3_W-1:0]   P3_RESET  = '1;

   if (HOST_AW < 2) begin : g_bad_haw
      $error("host address too narrow");
   end

   logic               win_open;
   logic               done_fall;
   logic               win_hit;
   logic [HOST_AW-1:0] win_host_addr;
   logic               mcu_acc;
   logic               cmd_hit;
   logic               cmd_wr;
   logic               host_ram_req;
   logic               halted;
   logic               int_req;
   ram_owner_e         owner;

   mwb_port3_track #(
      .P3_W            (P3_W),
      .GATE_BIT        (GATE_BIT),
      .DONE_BIT        (DONE_BIT),
      .RESET_VAL       (P3_RESET),
      .GATE_ACTIVE_LOW (1'b1)
   ) u_p3 (
      .clk       (clk),
      .rst_n     (rst_n),
      .p3_wr     (mcu_p3_wr),
      .p3_wdata  (mcu_p3_wdata),
      .win_open  (win_open),
      .done_fall (done_fall)
   );

   mwb_win_xlate #(
      .MCU_AW        (MCU_AW),
      .HOST_AW       (HOST_AW),
      .WIN_BYTES     (WIN_BYTES),
      .MCU_WIN_BASE  (MCU_WIN_BASE),
      .HOST_WIN_BASE (HOST_WIN_BASE),
      .ODD_LANE      (ODD_LANE)
   ) u_xlate (
      .mcu_addr       (mcu_addr),
      .win_hit        (win_hit),
      .host_byte_addr (win_host_addr)
   );

   // word-wide command: either byte lane of the word triggers it
   assign cmd_hit      = (host_addr[HOST_AW-1:1] == CMD_ADDR[HOST_AW-1:1]);
   assign cmd_wr       = host_req & host_we & cmd_hit;
   assign host_ram_req = host_req & ~cmd_hit;
   assign mcu_acc      = (mcu_rd | mcu_wr) & win_hit & win_open;

   mwb_halt_ctrl u_halt (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_wr    (cmd_wr),
      .done_fall (done_fall),
      .int_ack   (mcu_int_ack),
      .halted    (halted),
      .int_req   (int_req)
   );

   mwb_ram_arb #(
      .HOST_AW (HOST_AW),
      .DATA_W  (DATA_W)
   ) u_arb (
      .mcu_req    (mcu_acc),
      .mcu_we     (mcu_wr),
      .mcu_addr   (win_host_addr),
      .mcu_wdata  (mcu_wdata),
      .host_any   (host_req),
      .host_req   (host_ram_req),
      .host_we    (host_we),
      .host_addr  (host_addr),
      .host_wdata (host_wdata),
      .owner      (owner),
      .host_gnt   (host_gnt),
      .ram_en     (ram_en),
      .ram_we     (ram_we),
      .ram_addr   (ram_addr),
      .ram_wdata  (ram_wdata)
   );

   assign mcu_rdata  = (mcu_rd && owner == OWN_MCU) ? ram_rdata : IDLE_READ;
   assign host_rdata = (owner == OWN_HOST) ? ram_rdata : '0;
   assign host_halt  = halted;
   assign mcu_int0   = int_req;

endmodule

// File: rtl/mcu_window_bridge_chk.sv
module mcu_window_bridge_chk #(
   parameter int unsigned HOST_AW              = 24,
   parameter int unsigned HI_W                 = 19,
   parameter logic [HOST_AW-1:0] CMD_ADDR      = 24'hFE4002,
   parameter logic [HOST_AW-1:0] HOST_WIN_BASE = 24'hFFFFE0
) (
   input logic               clk,
   input logic               rst_n,
   input logic               host_req,
   input logic               host_we,
   input logic [HOST_AW-1:1] host_word,
   input logic               host_gnt,
   input logic               host_halt,
   input logic               mcu_int0,
   input logic               mcu_int_ack,
   input logic               p3_wr,
   input logic               p3_done_bit,
   input logic               ram_en,
   input logic [HOST_AW-1:0] ram_addr
);

   // R5: a command from a running host stalls it and raises the request
   p_cmd_halts_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (host_req && host_we && host_word == CMD_ADDR[HOST_AW-1:1] && !host_halt)
      |=> (host_halt && mcu_int0));

   // R6: release only follows a port write with completion bit low
   p_release_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(host_halt) |-> ($past(p3_wr) && !$past(p3_done_bit)));

   // R7: acknowledge drops the request
   p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mcu_int0 && mcu_int_ack) |=> !mcu_int0);

   // R8: request is never pending on a running host
   p_int_needs_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mcu_int0 |-> host_halt);

   // R9: a blocked host means the RAM cycle belongs to the window
   p_window_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_en && !host_gnt) |->
      (ram_addr[0] && ram_addr[HOST_AW-1:HOST_AW-HI_W] == HOST_WIN_BASE[HOST_AW-1:HOST_AW-HI_W]));

endmodule

bind mcu_window_bridge mcu_window_bridge_chk #(
   .HOST_AW       (HOST_AW),
   .HI_W          (HOST_AW - mwb_pkg::clog2_pos(WIN_BYTES) - 1),
   .CMD_ADDR      (CMD_ADDR),
   .HOST_WIN_BASE (HOST_WIN_BASE)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .host_req    (host_req),
   .host_we     (host_we),
   .host_word   (host_addr[HOST_AW-1:1]),
   .host_gnt    (host_gnt),
   .host_halt   (host_halt),
   .mcu_int0    (mcu_int0),
   .mcu_int_ack (mcu_int_ack),
   .p3_wr       (mcu_p3_wr),
   .p3_done_bit (mcu_p3_wdata[DONE_BIT]),
   .ram_en      (ram_en),
   .ram_addr    (ram_addr)
);

// File: tb/mcu_window_bridge_tb_top.sv
`timescale 1ns/100ps
module mcu_window_bridge_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_req = 1'b0, host_we = 1'b0;
   logic [23:0] host_addr = '0;
   logic [7:0]  host_wdata = '0;
   logic [7:0]  host_rdata;
   logic        host_gnt, host_halt;
   logic        mcu_rd = 1'b0, mcu_wr = 1'b0;
   logic [10:0] mcu_addr = '0;
   logic [7:0]  mcu_wdata = '0;
   logic [7:0]  mcu_rdata;
   logic        mcu_p3_wr = 1'b0;
   logic [7:0]  mcu_p3_wdata = '0;
   logic        mcu_int0;
   logic        mcu_int_ack = 1'b0;
   logic        ram_en, ram_we;
   logic [23:0] ram_addr;
   logic [7:0]  ram_wdata;
   logic [7:0]  ram_rdata;

   int n_cmp = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   // RAM model: read data is a fixed function of the address
   assign ram_rdata = ram_addr[7:0] ^ 8'hA5;

   mcu_window_bridge dut_i (
      .clk(clk), .rst_n(rst_n),
      .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
      .host_wdata(host_wdata), .host_rdata(host_rdata), .host_gnt(host_gnt),
      .host_halt(host_halt),
      .mcu_rd(mcu_rd), .mcu_wr(mcu_wr), .mcu_addr(mcu_addr),
      .mcu_wdata(mcu_wdata), .mcu_rdata(mcu_rdata),
      .mcu_p3_wr(mcu_p3_wr), .mcu_p3_wdata(mcu_p3_wdata),
      .mcu_int0(mcu_int0), .mcu_int_ack(mcu_int_ack),
      .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
      .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   task automatic p3_write(input logic [7:0] v);
      @(negedge clk);
      mcu_p3_wr = 1'b1;
      mcu_p3_wdata = v;
      @(negedge clk);
      mcu_p3_wr = 1'b0;
   endtask

   task automatic host_cmd(input logic [23:0] a);
      @(negedge clk);
      host_req = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = 8'h77;
      #1 chk("R10 command reaches RAM", ram_en, 1'b0);
      @(negedge clk);
      host_req = 1'b0; host_we = 1'b0;
   endtask

   task automatic mcu_read(input logic [10:0] a, input logic exp_en,
                           input logic [23:0] exp_addr, input logic [7:0] exp_d,
                           input string tag);
      @(negedge clk);
      mcu_rd = 1'b1; mcu_addr = a;
      #1;
      chk({tag, " ram_en"}, ram_en, exp_en);
      if (exp_en) chk({tag, " ram_addr"}, ram_addr, exp_addr);
      chk({tag, " rdata"}, mcu_rdata, exp_d);
      @(negedge clk);
      mcu_rd = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 halt in reset", host_halt, 1'b0);
      chk("R1 int0 in reset", mcu_int0, 1'b0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk("R1 halt after reset", host_halt, 1'b0);
      chk("R1 int0 after reset", mcu_int0, 1'b0);
      mcu_read(11'h7F3, 1'b0, '0, 8'hFF, "R1 window closed after reset");
   endtask

   task automatic t_translate();
      p3_write(8'hDF);   // bit5=0 opens, bit0=1
      for (int n = 0; n < 16; n += 5) begin
         mcu_read(11'h7F0 + 11'(n), 1'b1, 24'hFFFFE1 + 24'(2*n),
                  (8'hE1 + 8'(2*n)) ^ 8'hA5, "R2 read");
      end
      mcu_read(11'h7FF, 1'b1, 24'hFFFFFF, 8'hFF ^ 8'hA5, "R2 top read");
      @(negedge clk);
      mcu_wr = 1'b1; mcu_addr = 11'h7F5; mcu_wdata = 8'h3C;
      #1;
      chk("R2 write en", ram_en, 1'b1);
      chk("R2 write we", ram_we, 1'b1);
      chk("R2 write addr", ram_addr, 24'hFFFFEB);
      chk("R2 write data", ram_wdata, 8'h3C);
      @(negedge clk); mcu_wr = 1'b0;
   endtask

   task automatic t_outside();
      mcu_read(11'h7EF, 1'b0, '0, 8'hFF, "R3 below window");
      mcu_read(11'h000, 1'b0, '0, 8'hFF, "R3 zero address");
      @(negedge clk);
      mcu_wr = 1'b1; mcu_addr = 11'h3F5; mcu_wdata = 8'h11;
      #1 chk("R3 outside write", ram_en, 1'b0);
      @(negedge clk); mcu_wr = 1'b0;
   endtask

   task automatic t_gate();
      p3_write(8'hFF);
      mcu_read(11'h7F2, 1'b0, '0, 8'hFF, "R4 gated read");
      @(negedge clk);
      mcu_wr = 1'b1; mcu_addr = 11'h7F2; mcu_wdata = 8'h99;
      #1 chk("R4 gated write", ram_en, 1'b0);
      @(negedge clk); mcu_wr = 1'b0;
      p3_write(8'h01);   // reopen, bit0 high
      mcu_read(11'h7F2, 1'b1, 24'hFFFFE5, 8'hE5 ^ 8'hA5, "R4 reopened read");
   endtask

   task automatic t_cmd_and_arb();
      chk("R5 running before command", host_halt, 1'b0);
      host_cmd(24'hFE4003);
      chk("R5 halt after command", host_halt, 1'b1);
      chk("R5 int0 after command", mcu_int0, 1'b1);
      @(negedge clk);
      mcu_rd = 1'b1; mcu_addr = 11'h7F4;
      host_req = 1'b1; host_we = 1'b0; host_addr = 24'h001000;
      #1;
      chk("R9 host blocked", host_gnt, 1'b0);
      chk("R9 window owns RAM", ram_addr, 24'hFFFFE9);
      chk("R9 window data", mcu_rdata, 8'hE9 ^ 8'hA5);
      @(negedge clk);
      mcu_rd = 1'b0;
      #1;
      chk("R9 lone host granted", host_gnt, 1'b1);
      chk("R9 host address passed", ram_addr, 24'h001000);
      chk("R9 host read data", host_rdata, 8'h00 ^ 8'hA5);
      @(negedge clk); host_req = 1'b0;
   endtask

   task automatic t_ack_and_ignore();
      @(negedge clk); mcu_int_ack = 1'b1;
      @(negedge clk); mcu_int_ack = 1'b0;
      chk("R7 int0 cleared by ack", mcu_int0, 1'b0);
      chk("R7 halt kept by ack", host_halt, 1'b1);
      host_cmd(24'hFE4002);
      @(negedge clk);
      chk("R8 command while halted int0", mcu_int0, 1'b0);
      chk("R8 command while halted halt", host_halt, 1'b1);
   endtask

   task automatic t_release();
      p3_write(8'h01);   // 1 over 1
      chk("R6 1-over-1 keeps halt", host_halt, 1'b1);
      p3_write(8'h00);   // 1 to 0
      chk("R6 falling edge releases", host_halt, 1'b0);
      host_cmd(24'hFE4002);
      chk("R5 second command halts", host_halt, 1'b1);
      p3_write(8'h00);   // 0 over 0
      chk("R6 0-over-0 keeps halt", host_halt, 1'b1);
      p3_write(8'h01);   // 0 to 1
      chk("R6 rising keeps halt", host_halt, 1'b1);
      chk("R6 int0 still pending", mcu_int0, 1'b1);
      p3_write(8'h00);
      chk("R6 release clears halt", host_halt, 1'b0);
      chk("R6 release clears int0", mcu_int0, 1'b0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_translate();
      t_outside();
      t_gate();
      t_cmd_and_arb();
      t_ack_and_ignore();
      t_release();
      repeat (2) @(negedge clk);
      report();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      report();
      $finish;
   end

endmodule